// File: doc/BRIEF.md
# Directory Home-Node Coherence Controller

This block is the home node for a small shared memory in a cache-coherent multiprocessor that has no broadcast medium. For every memory block it keeps a directory entry with a coherence state and a presence vector, one bit per processor. The entry records which caches hold a copy and whether one of them holds the only valid, possibly modified copy. Local caches send it read misses, write misses and write-backs, one at a time. The controller answers each request explicitly. When other caches must act first, it sends point-to-point messages to them: invalidates to sharers, or a fetch or fetch-and-invalidate to the owner.

The controller serves one request at a time. A request either completes in the next cycle or keeps the block busy: it walks the sharer set one invalidate per cycle, or it waits for the owner to return its data. While the block is busy the request input is not ready. The backing memory sits inside the block. It is refreshed by owner write-backs, and by owner data that is fetched on behalf of a reader.

Top module: `home_dir_ctrl`

## Requirements
- R1: After reset every entry is Uncached with an empty presence vector, memory word i holds 0xB10C0000+i, req_ready is 1 and neither cmd_valid nor rep_valid is set.
- R2: A read miss (req_type 0) to an Uncached block gives, in the next cycle, a data reply (rep_kind 0) to the requester with the memory word. The block becomes Shared with only the requester present.
- R3: A write miss (req_type 1) to an Uncached block gives a data reply with the memory word in the next cycle. The block becomes Exclusive with the requester as its single present owner.
- R4: A read miss to a Shared block gives a data reply with the memory word in the next cycle. It adds the requester to the presence vector, and the block stays Shared.
- R5: A write miss to a Shared block sends one invalidate (cmd_kind 1) per cycle to every present processor, the requester included, in ascending index order, starting the cycle after acceptance. The data reply follows in the cycle after the last invalidate, and the block becomes Exclusive owned by the requester.
- R6: A read miss to an Exclusive block sends a fetch (cmd_kind 2) to the owner in the cycle after acceptance. The returned owner data is written to memory and replied to the requester one cycle after it arrives. The block becomes Shared with both the old owner and the requester present.
- R7: A write miss to an Exclusive block sends a fetch-and-invalidate (cmd_kind 3) to the owner. The returned data is forwarded in the reply one cycle after it arrives, memory is left unchanged, and the block stays Exclusive owned by the requester.
- R8: A write-back (req_type 2) from the owner of an Exclusive block stores req_data in memory and makes the block Uncached with an empty vector. An acknowledgement (rep_kind 1) goes to the requester in the next cycle.
- R9: A write-back from a processor that is not the owner of an Exclusive block, or any request with req_type 3, leaves directory and memory unchanged and is still acknowledged in the next cycle.
- R10: req_ready is low from the cycle after a request that needs remote messages is accepted until its reply cycle. Commands appear only while req_ready is low, and owner data offered while no fetch is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted on this edge when high |
| req_type | input | 2 | 0 read miss, 1 write miss, 2 write-back, 3 reserved |
| req_src | input | PW | Requesting processor index |
| req_addr | input | AW | Block address |
| req_data | input | DW | Write-back data |
| cmd_valid | output | 1 | Remote command valid this cycle |
| cmd_kind | output | 2 | 1 invalidate, 2 fetch, 3 fetch-and-invalidate |
| cmd_dst | output | PW | Destination processor |
| cmd_addr | output | AW | Block address of the command |
| own_valid | input | 1 | Owner data returned |
| own_data | input | DW | Owner block data |
| rep_valid | output | 1 | Reply valid this cycle |
| rep_kind | output | 1 | 0 data reply, 1 write-back acknowledgement |
| rep_dst | output | PW | Requester the reply goes to |
| rep_data | output | DW | Block data (zero for acknowledgements) |

## Verification
Two activities can share one cycle: the reply of one request can be on the outputs while the next request is being accepted, and the next request can reach the entry the reply just rewrote. The bench provokes this by sending requests back to back to the same block. A read then follows straight after an upgrade, a fetch or a write-back, so each later request is decoded against the state the earlier one wrote. A behavioural model predicts every command and reply with its exact cycle and the busy window of req_ready. Any message that is early, late, missing or carries a wrong field is reported.

// File: rtl/home_dir_pkg.sv
`timescale 1ns/1ps
package home_dir_pkg;

  typedef enum logic [1:0] {
    DS_UNC = 2'd0,
    DS_SHR = 2'd1,
    DS_EXC = 2'd2
  } dstate_e;

  typedef enum logic [1:0] {
    RQ_RD  = 2'd0,
    RQ_WR  = 2'd1,
    RQ_WB  = 2'd2,
    RQ_RSV = 2'd3
  } rqtype_e;

  typedef enum logic [1:0] {
    CM_NONE  = 2'd0,
    CM_INV   = 2'd1,
    CM_FETCH = 2'd2,
    CM_FINV  = 2'd3
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_INV   = 2'd1,
    ST_FETCH = 2'd2,
    ST_WAIT  = 2'd3
  } fsm_e;

  // Memory word that block idx holds after reset.
  function automatic logic [31:0] seed_word(input int unsigned idx);
    return 32'hB10C_0000 + 32'(idx);
  endfunction

  // Index of the lowest set bit; 0 for an empty vector.
  function automatic int unsigned low_index(input logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) r = 32'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/home_dir_table.sv
`timescale 1ns/1ps
module home_dir_table
  import home_dir_pkg::*;
#(
  parameter int NBLK  = 8,
  parameter int NPROC = 4,
  parameter int AW    = $clog2(NBLK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    rd_addr,
  output dstate_e          rd_state,
  output logic [NPROC-1:0] rd_share,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  dstate_e          wr_state,
  input  logic [NPROC-1:0] wr_share
);

  dstate_e          st_q [NBLK];
  logic [NPROC-1:0] sh_q [NBLK];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBLK; i++) begin
        st_q[i] <= DS_UNC;
        sh_q[i] <= '0;
      end
    end else if (wr_en) begin
      st_q[wr_addr] <= wr_state;
      sh_q[wr_addr] <= wr_share;
    end
  end

  assign rd_state = st_q[rd_addr];
  assign rd_share = sh_q[rd_addr];

endmodule

// File: rtl/home_blk_mem.sv
`timescale 1ns/1ps
module home_blk_mem
  import home_dir_pkg::*;
#(
  parameter int NBLK = 8,
  parameter int DW   = 32,
  parameter int AW   = $clog2(NBLK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);

  logic [DW-1:0] word_q [NBLK];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NBLK; i++) begin
        word_q[i] <= DW'(seed_word(32'(i)));
      end
    end else if (wr_en) begin
      word_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = word_q[rd_addr];

endmodule

// File: rtl/home_inv_walker.sv
`timescale 1ns/1ps
module home_inv_walker #(
  parameter int NPROC = 4,
  parameter int PW    = $clog2(NPROC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NPROC-1:0] load_mask,
  input  logic             step,
  output logic [PW-1:0]    cur,
  output logic             last
);

  logic [NPROC-1:0] mask_q;

  always_comb begin
    cur = '0;
    for (int i = NPROC - 1; i >= 0; i--) begin
      if (mask_q[i]) cur = PW'(i);
    end
  end

  assign last = (mask_q != '0) && ((mask_q & (mask_q - NPROC'(1))) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (load) begin
      mask_q <= load_mask;
    end else if (step) begin
      mask_q <= mask_q & ~(NPROC'(1) << cur);
    end
  end

endmodule

// File: rtl/home_dir_ctrl.sv
`timescale 1ns/1ps
module home_dir_ctrl
  import home_dir_pkg::*;
#(
  parameter  int NPROC = 4,
  parameter  int NBLK  = 8,
  parameter  int DW    = 32,
  localparam int PW    = $clog2(NPROC),
  localparam int AW    = $clog2(NBLK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_type,
  input  logic [PW-1:0] req_src,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          cmd_valid,
  output logic [1:0]    cmd_kind,
  output logic [PW-1:0] cmd_dst,
  output logic [AW-1:0] cmd_addr,
  input  logic          own_valid,
  input  logic [DW-1:0] own_data,
  output logic          rep_valid,
  output logic          rep_kind,
  output logic [PW-1:0] rep_dst,
  output logic [DW-1:0] rep_data
);

  fsm_e          st_q, st_d;
  logic [PW-1:0] cur_src_q, cur_own_q;
  logic [AW-1:0] cur_addr_q;
  logic          cur_is_rd_q;

  // Named internal events, brought out for the checker.
  logic ev_accept;
  logic ev_owner_take;
  logic ev_inv_done;

  logic [AW-1:0]    lk_addr;
  logic [PW-1:0]    lk_src;
  logic [NPROC-1:0] src_bit;
  rqtype_e          rq;

  dstate_e          ent_state;
  logic [NPROC-1:0] ent_share;
  logic [DW-1:0]    mem_rd;

  logic             dir_we;
  dstate_e          dir_wstate;
  logic [NPROC-1:0] dir_wshare;
  logic             mem_we;
  logic [DW-1:0]    mem_wdata;

  logic             wk_load, wk_step, wk_last;
  logic [PW-1:0]    wk_cur;

  logic             latch;
  logic             rep_fire, rep_kind_n;
  logic [DW-1:0]    rep_data_n;

  assign req_ready     = (st_q == ST_IDLE);
  assign ev_accept     = req_valid && req_ready;
  assign ev_owner_take = (st_q == ST_WAIT) && own_valid;
  assign ev_inv_done   = (st_q == ST_INV) && wk_last;

  assign lk_addr = req_ready ? req_addr : cur_addr_q;
  assign lk_src  = req_ready ? req_src  : cur_src_q;
  assign src_bit = NPROC'(1) << lk_src;
  assign rq      = rqtype_e'(req_type);

  home_dir_table #(.NBLK(NBLK), .NPROC(NPROC), .AW(AW)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_addr  (lk_addr),
    .rd_state (ent_state),
    .rd_share (ent_share),
    .wr_en    (dir_we),
    .wr_addr  (lk_addr),
    .wr_state (dir_wstate),
    .wr_share (dir_wshare)
  );

  home_blk_mem #(.NBLK(NBLK), .DW(DW), .AW(AW)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (lk_addr),
    .rd_data (mem_rd),
    .wr_en   (mem_we),
    .wr_addr (lk_addr),
    .wr_data (mem_wdata)
  );

  home_inv_walker #(.NPROC(NPROC), .PW(PW)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (wk_load),
    .load_mask (ent_share),
    .step      (wk_step),
    .cur       (wk_cur),
    .last      (wk_last)
  );

  // Request decode and directory update.
  always_comb begin
    st_d       = st_q;
    latch      = 1'b0;
    dir_we     = 1'b0;
    dir_wstate = DS_UNC;
    dir_wshare = '0;
    mem_we     = 1'b0;
    mem_wdata  = '0;
    wk_load    = 1'b0;
    wk_step    = 1'b0;
    rep_fire   = 1'b0;
    rep_kind_n = 1'b0;
    rep_data_n = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (ev_accept) begin
          latch = 1'b1;
          unique case (rq)
            RQ_RD: begin
              if (ent_state == DS_EXC) begin
                st_d = ST_FETCH;
              end else begin
                dir_we     = 1'b1;
                dir_wstate = DS_SHR;
                dir_wshare = (ent_state == DS_SHR) ? (ent_share | src_bit) : src_bit;
                rep_fire   = 1'b1;
                rep_data_n = mem_rd;
              end
            end
            RQ_WR: begin
              if (ent_state == DS_EXC) begin
                st_d = ST_FETCH;
              end else if (ent_state == DS_SHR) begin
                wk_load = 1'b1;
                st_d    = ST_INV;
              end else begin
                dir_we     = 1'b1;
                dir_wstate = DS_EXC;
                dir_wshare = src_bit;
                rep_fire   = 1'b1;
                rep_data_n = mem_rd;
              end
            end
            default: begin
              rep_fire   = 1'b1;
              rep_kind_n = 1'b1;
              if (rq == RQ_WB && ent_state == DS_EXC && ent_share == src_bit) begin
                mem_we     = 1'b1;
                mem_wdata  = req_data;
                dir_we     = 1'b1;
                dir_wstate = DS_UNC;
                dir_wshare = '0;
              end
            end
          endcase
        end
      end
      ST_INV: begin
        wk_step = 1'b1;
        if (wk_last) begin
          dir_we     = 1'b1;
          dir_wstate = DS_EXC;
          dir_wshare = src_bit;
          rep_fire   = 1'b1;
          rep_data_n = mem_rd;
          st_d       = ST_IDLE;
        end
      end
      ST_FETCH: begin
        st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (own_valid) begin
          rep_fire   = 1'b1;
          rep_data_n = own_data;
          dir_we     = 1'b1;
          if (cur_is_rd_q) begin
            mem_we     = 1'b1;
            mem_wdata  = own_data;
            dir_wstate = DS_SHR;
            dir_wshare = ent_share | src_bit;
          end else begin
            dir_wstate = DS_EXC;
            dir_wshare = src_bit;
          end
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Remote command outputs.
  assign cmd_valid = (st_q == ST_INV) || (st_q == ST_FETCH);
  assign cmd_kind  = (st_q == ST_INV) ? CM_INV : (cur_is_rd_q ? CM_FETCH : CM_FINV);
  assign cmd_dst   = (st_q == ST_INV) ? wk_cur : cur_own_q;
  assign cmd_addr  = cur_addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      cur_src_q   <= '0;
      cur_own_q   <= '0;
      cur_addr_q  <= '0;
      cur_is_rd_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (latch) begin
        cur_src_q   <= req_src;
        cur_addr_q  <= req_addr;
        cur_is_rd_q <= (rq == RQ_RD);
        cur_own_q   <= PW'(low_index(32'(ent_share)));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rep_valid <= 1'b0;
      rep_kind  <= 1'b0;
      rep_dst   <= '0;
      rep_data  <= '0;
    end else begin
      rep_valid <= rep_fire;
      if (rep_fire) begin
        rep_kind <= rep_kind_n;
        rep_dst  <= lk_src;
        rep_data <= rep_data_n;
      end
    end
  end

endmodule

// File: rtl/home_dir_chk.sv
`timescale 1ns/1ps
module home_dir_chk #(
  parameter int NPROC = 4,
  parameter int PW    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [1:0]       req_type,
  input logic             cmd_valid,
  input logic [1:0]       cmd_kind,
  input logic [PW-1:0]    cmd_dst,
  input logic             own_valid,
  input logic             rep_valid,
  input logic             rep_kind,
  input logic             dir_we,
  input logic [1:0]       dir_wstate,
  input logic [NPROC-1:0] dir_wshare,
  input logic             ev_owner_take,
  input logic             ev_inv_done
);

  a_r10_cmd_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !req_ready);

  a_r6_fetch_then_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind != 2'd1) |=> (!req_ready && !cmd_valid));

  a_r5_inv_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == 2'd1 && $past(cmd_valid && cmd_kind == 2'd1))
      |-> (cmd_dst > $past(cmd_dst)));

  a_r5_reply_after_last_inv: assert property (@(posedge clk) disable iff (!rst_n)
    ev_inv_done |=> (rep_valid && !rep_kind && req_ready));

  a_r8_wb_acked_next: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_type == 2'd2) |=> (rep_valid && rep_kind));

  a_r10_stray_owner_data: assert property (@(posedge clk) disable iff (!rst_n)
    (own_valid && req_ready && !req_valid) |=> !rep_valid);

  a_r6_owner_data_replied: assert property (@(posedge clk) disable iff (!rst_n)
    ev_owner_take |=> (rep_valid && !rep_kind));

  a_r3_excl_single_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_we && dir_wstate == 2'd2) |-> ($countones(dir_wshare) == 1));

  a_r2_shared_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_we && dir_wstate == 2'd1) |-> (dir_wshare != '0));

endmodule

bind home_dir_ctrl home_dir_chk #(.NPROC(NPROC), .PW(PW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_type      (req_type),
  .cmd_valid     (cmd_valid),
  .cmd_kind      (cmd_kind),
  .cmd_dst       (cmd_dst),
  .own_valid     (own_valid),
  .rep_valid     (rep_valid),
  .rep_kind      (rep_kind),
  .dir_we        (dir_we),
  .dir_wstate    (dir_wstate),
  .dir_wshare    (dir_wshare),
  .ev_owner_take (ev_owner_take),
  .ev_inv_done   (ev_inv_done)
);

// File: tb/sim_home_dir_ctrl.sv
`timescale 1ns/1ps
module sim_home_dir_ctrl;

  localparam int NP = 4;
  localparam int NB = 8;
  localparam int DW = 32;
  localparam int PW = 2;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_type = '0;
  logic [PW-1:0] req_src = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic          cmd_valid;
  logic [1:0]    cmd_kind;
  logic [PW-1:0] cmd_dst;
  logic [AW-1:0] cmd_addr;
  logic          own_valid = 1'b0;
  logic [DW-1:0] own_data = '0;
  logic          rep_valid;
  logic          rep_kind;
  logic [PW-1:0] rep_dst;
  logic [DW-1:0] rep_data;

  always #2.5 clk = ~clk;

  home_dir_ctrl #(.NPROC(NP), .NBLK(NB), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
    .req_src(req_src), .req_addr(req_addr), .req_data(req_data),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_dst(cmd_dst), .cmd_addr(cmd_addr),
    .own_valid(own_valid), .own_data(own_data),
    .rep_valid(rep_valid), .rep_kind(rep_kind), .rep_dst(rep_dst), .rep_data(rep_data)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Behavioural reference: 0 Uncached, 1 Shared, 2 Exclusive.
  int          m_st  [NB];
  int          m_sh  [NB];
  logic [31:0] m_mem [NB];

  typedef struct { int cyc; int kind; int dst; int addr; string tag; } cx_t;
  typedef struct { int cyc; int kind; int dst; logic [31:0] data; string tag; } rx_t;
  cx_t cq[$];
  rx_t rq[$];
  int    busy_lo = -1;
  int    busy_hi = -2;
  string busy_tag = "R10";
  int    own_lat = 1;

  function automatic logic [31:0] odat(int a, int o);
    return 32'h0D00_0000 + 32'(a * 256 + o);
  endfunction

  function automatic int lowbit(int v);
    for (int i = 0; i < NP; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic push_c(int c, int k, int d, int a, string tag);
    cx_t e;
    e.cyc = c; e.kind = k; e.dst = d; e.addr = a; e.tag = tag;
    cq.push_back(e);
  endtask

  task automatic push_r(int c, int k, int d, logic [31:0] v, string tag);
    rx_t e;
    e.cyc = c; e.kind = k; e.dst = d; e.data = v; e.tag = tag;
    rq.push_back(e);
  endtask

  // Predict messages for a request accepted at the edge after negedge t.
  task automatic model(int ty, int src, int a, logic [31:0] d, int lat, int t);
    int own, n;
    logic [31:0] v;
    own = lowbit(m_sh[a]);
    case (ty)
      0: begin
        if (m_st[a] == 0) begin
          push_r(t + 1, 0, src, m_mem[a], "R2");
          m_st[a] = 1; m_sh[a] = 1 << src;
        end else if (m_st[a] == 1) begin
          push_r(t + 1, 0, src, m_mem[a], "R4");
          m_sh[a] = m_sh[a] | (1 << src);
        end else begin
          v = odat(a, own);
          push_c(t + 1, 2, own, a, "R6");
          push_r(t + 2 + lat, 0, src, v, "R6");
          busy_lo = t + 1; busy_hi = t + 1 + lat; busy_tag = "R10";
          m_mem[a] = v; m_st[a] = 1; m_sh[a] = m_sh[a] | (1 << src);
        end
      end
      1: begin
        if (m_st[a] == 0) begin
          push_r(t + 1, 0, src, m_mem[a], "R3");
          m_st[a] = 2; m_sh[a] = 1 << src;
        end else if (m_st[a] == 1) begin
          n = 0;
          for (int p = 0; p < NP; p++) begin
            if (m_sh[a][p]) begin
              n++;
              push_c(t + n, 1, p, a, "R5");
            end
          end
          push_r(t + n + 1, 0, src, m_mem[a], "R5");
          busy_lo = t + 1; busy_hi = t + n; busy_tag = "R10";
          m_st[a] = 2; m_sh[a] = 1 << src;
        end else begin
          v = odat(a, own);
          push_c(t + 1, 3, own, a, "R7");
          push_r(t + 2 + lat, 0, src, v, "R7");
          busy_lo = t + 1; busy_hi = t + 1 + lat; busy_tag = "R10";
          m_sh[a] = 1 << src;
        end
      end
      default: begin
        if (ty == 2 && m_st[a] == 2 && m_sh[a] == (1 << src)) begin
          push_r(t + 1, 1, src, 32'h0, "R8");
          m_mem[a] = d; m_st[a] = 0; m_sh[a] = 0;
        end else begin
          push_r(t + 1, 1, src, 32'h0, "R9");
        end
      end
    endcase
  endtask

  // Called at a negedge; returns at the negedge after acceptance.
  task automatic send(int ty, int src, int a, logic [31:0] d, int lat);
    own_lat   = lat;
    req_type  = 2'(ty);
    req_src   = PW'(src);
    req_addr  = AW'(a);
    req_data  = d;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    model(ty, src, a, d, lat, cyc);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Cycle-by-cycle comparison against the reference.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (cmd_valid) begin
        if (cq.size() == 0 || cq[0].cyc != cyc) begin
          chk("R10", "unexpected command", 32'(cmd_kind), 32'h0);
          if (cq.size() != 0 && cq[0].cyc < cyc) void'(cq.pop_front());
        end else begin
          chk(cq[0].tag, "command kind", 32'(cmd_kind), 32'(cq[0].kind));
          chk(cq[0].tag, "command dst",  32'(cmd_dst),  32'(cq[0].dst));
          chk(cq[0].tag, "command addr", 32'(cmd_addr), 32'(cq[0].addr));
          void'(cq.pop_front());
        end
      end else if (cq.size() != 0 && cq[0].cyc <= cyc) begin
        chk(cq[0].tag, "missing command", 32'h0, 32'h1);
        void'(cq.pop_front());
      end
      if (rep_valid) begin
        if (rq.size() == 0 || rq[0].cyc != cyc) begin
          chk("R10", "unexpected reply", rep_data, 32'h0);
          if (rq.size() != 0 && rq[0].cyc < cyc) void'(rq.pop_front());
        end else begin
          chk(rq[0].tag, "reply kind", 32'(rep_kind), 32'(rq[0].kind));
          chk(rq[0].tag, "reply dst",  32'(rep_dst),  32'(rq[0].dst));
          chk(rq[0].tag, "reply data", rep_data,      rq[0].data);
          void'(rq.pop_front());
        end
      end else if (rq.size() != 0 && rq[0].cyc <= cyc) begin
        chk(rq[0].tag, "missing reply", 32'h0, 32'h1);
        void'(rq.pop_front());
      end
      if (cyc >= busy_lo && cyc <= busy_hi) begin
        chk(busy_tag, "ready while busy", 32'(req_ready), 32'h0);
      end
    end
  end

  // Remote owner model: returns its block after own_lat cycles.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && cmd_valid && cmd_kind >= 2'd2) begin
        int a, o;
        a = int'(cmd_addr);
        o = int'(cmd_dst);
        repeat (own_lat) @(negedge clk);
        own_data  = odat(a, o);
        own_valid = 1'b1;
        @(negedge clk);
        own_valid = 1'b0;
        own_data  = '0;
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog: actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    int seed;
    for (int i = 0; i < NB; i++) begin
      m_st[i] = 0; m_sh[i] = 0; m_mem[i] = 32'hB10C_0000 + 32'(i);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset.
    chk("R1", "ready after reset", 32'(req_ready), 32'h1);
    chk("R1", "cmd after reset",   32'(cmd_valid), 32'h0);
    chk("R1", "reply after reset", 32'(rep_valid), 32'h0);

    // R2, R4: sharers accumulate, back to back.
    send(0, 0, 0, 0, 1);
    send(0, 1, 0, 0, 1);
    send(0, 2, 0, 0, 1);
    // R5: upgrade with three sharers.
    send(1, 3, 0, 0, 1);
    // R6: read of an exclusive block, then the memory copy is read back.
    send(0, 1, 0, 0, 2);
    send(0, 0, 0, 0, 1);
    // R5: invalidate includes the requester itself.
    send(1, 1, 0, 0, 1);
    // R7: ownership transfer.
    send(1, 2, 0, 0, 3);
    // R9: write-back from a non-owner.
    send(2, 0, 0, 32'hDEAD_0000, 1);
    // R8: write-back from the owner, then read it back.
    send(2, 2, 0, 32'hFEED_0001, 1);
    send(0, 3, 0, 0, 1);
    // R3 then R8 on another block.
    send(1, 0, 5, 0, 1);
    send(2, 0, 5, 32'hCAFE_0005, 1);
    send(0, 1, 5, 0, 1);
    // R9: reserved type and a write-back from a sharer change nothing.
    send(3, 1, 5, 32'h1111_1111, 1);
    send(2, 1, 5, 32'h2222_2222, 1);
    send(0, 2, 5, 0, 1);

    // R10: stray owner data while idle gives no reply.
    own_data  = 32'h5555_AAAA;
    own_valid = 1'b1;
    @(negedge clk);
    own_valid = 1'b0;
    own_data  = '0;
    chk("R10", "reply to stray owner data", 32'(rep_valid), 32'h0);
    send(0, 2, 7, 0, 1);

    // R1: untouched blocks hold their reset words.
    for (int a = 1; a < 5; a++) send(0, 3, a, 0, 1);
    send(0, 3, 6, 0, 1);

    // Mixed traffic on a few blocks.
    seed = 32'h1234_5678;
    for (int k = 0; k < 80; k++) begin
      int ty, src, a, lat;
      seed = seed * 1103515245 + 12345;
      ty  = (seed >>> 8) & 3;
      src = (seed >>> 12) & 3;
      a   = (seed >>> 16) & 3;
      lat = 1 + ((seed >>> 20) & 3);
      if (ty == 3 && ((seed >>> 24) & 1)) ty = 0;
      send(ty, src, a, 32'(seed), lat);
    end

    repeat (12) @(negedge clk);
    chk("R10", "commands left pending", 32'(cq.size()), 32'h0);
    chk("R10", "replies left pending",  32'(rq.size()), 32'h0);
    finish_run();
  end

endmodule